// File: doc/BRIEF.md
# Mixed-Tap Thermometer Fine-Code Encoder

This block sits behind the sampling flip-flops of a tapped delay line in a time-to-digital converter. Each group of four taps belongs to one carry element. Every tap position in the group is wired either to a sum output or to a carry output, or it is left unused. A compile-time four-letter pattern records that wiring, and the same pattern repeats for every element. Each cycle the block can take one snapshot and produce the number of taps that the hit edge has already flipped.

The block gathers the sum taps into one group and the carry taps into another. A sum output and its carry output always sit at opposite logic levels, so the carry group is inverted relative to the sum group. A per-sample input gives the hit edge direction, and both groups are normalised against it. Each group passes through a three-tap bubble corrector that yields a one-hot edge marker. An OR tree then turns the marker into a binary sub-count. The two sub-counts are added.

The work is split over three register stages: edge correction, tree encoding and addition. A result appears a fixed three cycles after its snapshot, and a new snapshot can be accepted on every cycle.

Top module: `mtap_fine_encoder`

## Requirements
- R1: Letter k of the four-letter pattern `PATTERN` is read left to right with k = 0..3. It sets the type of tap 4e+k for every element e: `S` means sum, `C` means carry and `N` means unused.
- R2: With `hitRising` = 1, a sum tap counts as flipped when it reads 1 and a carry tap counts as flipped when it reads 0. With `hitRising` = 0, both conditions are reversed.
- R3: Suppose the flipped taps of each group form a run that starts at the group's lowest-index tap. Then `fineCode` equals the total number of flipped sum and carry taps.
- R4: A single flipped tap is ignored if it is not the first tap of its group and the tap just below it in the same group is not flipped.
- R5: A snapshot with no flipped tap gives code 0. A snapshot with every sum and carry tap flipped gives the number of sum and carry taps. No result is ever larger than that number.
- R6: `codeValid` goes high exactly three cycles after a cycle with `validIn` high: a snapshot sampled at clock edge k shows at the output after edge k+2. Otherwise `codeValid` stays low. A snapshot is accepted on every cycle.
- R7: `fineCode` keeps the last result until the next result arrives. Snapshots presented while `validIn` is low have no effect on it.
- R8: While `rst_n` is low, `codeValid` and `fineCode` are both 0.
- R9: Taps marked `N` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Snapshot on `tapSnap` is to be encoded |
| hitRising | input | 1 | 1 for a 0-to-1 hit edge, 0 for a 1-to-0 edge |
| tapSnap | input | 4*NUM_ELEM | Sampled delay-line taps, tap 0 nearest the hit input |
| codeValid | output | 1 | `fineCode` carries a new result this cycle |
| fineCode | output | bits for (sum+carry tap count) | Number of flipped taps |

## Verification
The assertions check on every cycle that the valid flag trails its input by exactly three cycles. They also check that the output code stays unchanged between results, and that neither a sub-count nor the total goes past its group size. Only the bench's scenarios can show the actual count values. These cover both edge directions, the pattern-dependent assignment of taps, the rejection of an isolated flipped tap above the edge, the indifference to unused taps, and the two end points of an empty line and a fully flipped line. The bench runs two instances side by side, one with `SCSC` and one with `SNCC`, and compares them with a behavioural model on every clock.

// File: rtl/mtap_pkg.sv
package mtap_pkg;

  // Stage strobes passed from control to datapath
  typedef struct packed {
    logic corrLd;   // load bubble-corrected one-hot vectors
    logic treeLd;   // load tree-encoded sub-counts
    logic addLd;    // load the summed fine code
  } mtapStrobe_t;

  // Letter k (0 = leftmost) of a four-character pattern
  function automatic logic [7:0] patChar(logic [31:0] pat, int k);
    return pat[8*(3-k) +: 8];
  endfunction

  // Number of taps of one type inside a single element
  function automatic int perElem(logic [31:0] pat, logic [7:0] ch);
    int cnt = 0;
    for (int k = 0; k < 4; k++)
      if (patChar(pat, k) == ch) cnt++;
    return cnt;
  endfunction

  // Position inside the element of the n-th tap of a type
  function automatic int nthPos(logic [31:0] pat, logic [7:0] ch, int n);
    int cnt = 0;
    for (int k = 0; k < 4; k++) begin
      if (patChar(pat, k) == ch) begin
        if (cnt == n) return k;
        cnt++;
      end
    end
    return 0;
  endfunction

  // Bits needed to hold values 0..n
  function automatic int bitsFor(int n);
    return (n <= 1) ? 1 : $clog2(n + 1);
  endfunction

  // Width of the final fine code
  function automatic int codeBits(int nElem, logic [31:0] pat);
    return bitsFor(nElem * (perElem(pat, "S") + perElem(pat, "C")));
  endfunction

endpackage

// File: rtl/mtap_ctrl.sv
module mtap_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  validIn,
  output mtap_pkg::mtapStrobe_t strobe,
  output logic                  codeValid
);

  logic corrDone;
  logic treeDone;
  logic addDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corrDone <= 1'b0;
      treeDone <= 1'b0;
      addDone  <= 1'b0;
    end else begin
      corrDone <= validIn;
      treeDone <= corrDone;
      addDone  <= treeDone;
    end
  end

  assign strobe.corrLd = validIn;
  assign strobe.treeLd = corrDone;
  assign strobe.addLd  = treeDone;
  assign codeValid     = addDone;

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    validIn |=> ##2 codeValid);

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !validIn |=> ##2 !codeValid);

endmodule

// File: rtl/mtap_group_coder.sv
module mtap_group_coder #(
  parameter int N = 16,
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         corrLd,
  input  logic         treeLd,
  input  logic [N-1:0] therm,
  output logic [W-1:0] subCode
);

  // Padded view: a flipped tap below index 0, an unflipped one above N-1
  logic [N+1:0] padded;
  logic [N-1:0] edgeComb;
  logic [N-1:0] onehotQ;
  logic [W-1:0] treeComb;
  logic [W-1:0] codeQ;

  assign padded = {1'b0, therm, 1'b1};

  // Edge at i: tap i and tap i-1 flipped, tap i+1 not flipped
  for (genvar i = 0; i < N; i++) begin : g_edge
    assign edgeComb[i] = padded[i+1] & padded[i] & ~padded[i+2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      onehotQ <= '0;
    else if (corrLd) onehotQ <= edgeComb;
  end

  // One-hot position i encodes count i+1: OR tree per output bit
  always_comb begin
    treeComb = '0;
    for (int i = 0; i < N; i++)
      for (int b = 0; b < W; b++)
        if ((((i + 1) >> b) & 1) == 1)
          treeComb[b] = treeComb[b] | onehotQ[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      codeQ <= '0;
    else if (treeLd) codeQ <= treeComb;
  end

  assign subCode = codeQ;

  // R5
  sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(codeQ) <= N);

endmodule

// File: rtl/mtap_datapath.sv
module mtap_datapath #(
  parameter int          NUM_ELEM = 8,
  parameter logic [31:0] PATTERN  = "SCSC"
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            hitRising,
  input  logic [4*NUM_ELEM-1:0]                           tapSnap,
  input  mtap_pkg::mtapStrobe_t                           strobe,
  output logic [mtap_pkg::codeBits(NUM_ELEM, PATTERN)-1:0] fineCode
);

  localparam int PER_S = mtap_pkg::perElem(PATTERN, "S");
  localparam int PER_C = mtap_pkg::perElem(PATTERN, "C");
  localparam int NS    = NUM_ELEM * PER_S;
  localparam int NC    = NUM_ELEM * PER_C;
  localparam int NS_V  = (NS > 0) ? NS : 1;
  localparam int NC_V  = (NC > 0) ? NC : 1;
  localparam int SW    = mtap_pkg::bitsFor(NS);
  localparam int CW    = mtap_pkg::bitsFor(NC);
  localparam int OW    = mtap_pkg::codeBits(NUM_ELEM, PATTERN);

  logic [NS_V-1:0] sumTherm;
  logic [NC_V-1:0] carryTherm;
  logic [SW-1:0]   sumSub;
  logic [CW-1:0]   carrySub;
  logic [OW-1:0]   codeQ;
  logic            unusedTaps;

  // Unused-tap positions are never routed into either group
  assign unusedTaps = ^tapSnap;

  // Sum taps: flipped when equal to the edge direction
  for (genvar j = 0; j < NS; j++) begin : g_sumTap
    localparam int TAP = 4*(j / PER_S) + mtap_pkg::nthPos(PATTERN, "S", j % PER_S);
    assign sumTherm[j] = tapSnap[TAP] ~^ hitRising;
  end

  // Carry taps sit at the opposite level: flipped when differing
  for (genvar j = 0; j < NC; j++) begin : g_carryTap
    localparam int TAP = 4*(j / PER_C) + mtap_pkg::nthPos(PATTERN, "C", j % PER_C);
    assign carryTherm[j] = tapSnap[TAP] ^ hitRising;
  end

  if (NS > 0) begin : g_sumCoder
    mtap_group_coder #(.N(NS), .W(SW)) i_sumCoder (
      .clk     (clk),
      .rst_n   (rst_n),
      .corrLd  (strobe.corrLd),
      .treeLd  (strobe.treeLd),
      .therm   (sumTherm),
      .subCode (sumSub)
    );
  end else begin : g_noSum
    assign sumTherm = '0;
    assign sumSub   = '0;
  end

  if (NC > 0) begin : g_carryCoder
    mtap_group_coder #(.N(NC), .W(CW)) i_carryCoder (
      .clk     (clk),
      .rst_n   (rst_n),
      .corrLd  (strobe.corrLd),
      .treeLd  (strobe.treeLd),
      .therm   (carryTherm),
      .subCode (carrySub)
    );
  end else begin : g_noCarry
    assign carryTherm = '0;
    assign carrySub   = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            codeQ <= '0;
    else if (strobe.addLd) codeQ <= OW'(sumSub) + OW'(carrySub);
  end

  assign fineCode = codeQ;

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.addLd |=> $stable(fineCode));

  // R5
  max_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fineCode) <= NS + NC);

endmodule

// File: rtl/mtap_fine_encoder.sv
module mtap_fine_encoder #(
  parameter int          NUM_ELEM = 8,
  parameter logic [31:0] PATTERN  = "SCSC"
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             validIn,
  input  logic                                             hitRising,
  input  logic [4*NUM_ELEM-1:0]                            tapSnap,
  output logic                                             codeValid,
  output logic [mtap_pkg::codeBits(NUM_ELEM, PATTERN)-1:0] fineCode
);

  mtap_pkg::mtapStrobe_t strobe;

  mtap_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .validIn   (validIn),
    .strobe    (strobe),
    .codeValid (codeValid)
  );

  mtap_datapath #(.NUM_ELEM(NUM_ELEM), .PATTERN(PATTERN)) i_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .hitRising (hitRising),
    .tapSnap   (tapSnap),
    .strobe    (strobe),
    .fineCode  (fineCode)
  );

endmodule

// File: tb/test_mtap_fine_encoder.sv
module test_mtap_fine_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int NTAP       = 32;
  localparam logic [31:0] PAT_A = "SCSC";
  localparam logic [31:0] PAT_B = "SNCC";

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            validIn = 1'b0;
  logic            hitRising = 1'b1;
  logic [NTAP-1:0] snapA = '0;
  logic [NTAP-1:0] snapB = '0;
  logic            validA, validB;
  logic [5:0]      codeA;
  logic [4:0]      codeB;

  int checks = 0;
  int errors = 0;

  bit    qv[$];
  int    qa[$];
  int    qb[$];
  string qt[$];
  int    holdA = 0;
  int    holdB = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtap_fine_encoder #(.NUM_ELEM(8), .PATTERN(PAT_A)) i_mtap_fine_encoder (
    .clk(clk), .rst_n(rst_n), .validIn(validIn), .hitRising(hitRising),
    .tapSnap(snapA), .codeValid(validA), .fineCode(codeA)
  );

  mtap_fine_encoder #(.NUM_ELEM(8), .PATTERN(PAT_B)) i_mtap_fine_encoder_b (
    .clk(clk), .rst_n(rst_n), .validIn(validIn), .hitRising(hitRising),
    .tapSnap(snapB), .codeValid(validB), .fineCode(codeB)
  );

  function automatic logic [7:0] letter(logic [31:0] pat, int t);
    return pat[8*(3 - (t % 4)) +: 8];
  endfunction

  // Behavioural model: per group, list flipped states, locate the edge
  function automatic int refCode(logic [NTAP-1:0] s, bit r, logic [31:0] pat);
    int total = 0;
    for (int g = 0; g < 2; g++) begin
      bit f[$];
      int cnt = 0;
      for (int t = 0; t < NTAP; t++) begin
        if (g == 0 && letter(pat, t) == "S") f.push_back(s[t] == r);
        if (g == 1 && letter(pat, t) == "C") f.push_back(s[t] != r);
      end
      for (int i = 0; i < f.size(); i++) begin
        bit below = (i == 0) ? 1'b1 : f[i-1];
        bit above = (i == f.size() - 1) ? 1'b0 : f[i+1];
        if (f[i] && below && !above) cnt = i + 1;
      end
      total += cnt;
    end
    return total;
  endfunction

  // Physical line with the edge past tap p-1; optional glitch; noise on unused taps
  function automatic logic [NTAP-1:0] makeSnap(int p, bit r, logic [31:0] pat,
                                               int glitch, logic [NTAP-1:0] noise);
    logic [NTAP-1:0] s;
    for (int t = 0; t < NTAP; t++) begin
      bit fl = (t < p) || (t == glitch);
      if (letter(pat, t) == "S")      s[t] = fl ? r : !r;
      else if (letter(pat, t) == "C") s[t] = fl ? !r : r;
      else                            s[t] = noise[t];
    end
    return s;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Called at a negative edge: drive, advance one clock, compare at the next negative edge
  task automatic tickRaw(bit v, logic [NTAP-1:0] sA, logic [NTAP-1:0] sB, bit r, string tag);
    bit    ev;
    int    ea, eb;
    string et;
    validIn   = v;
    hitRising = r;
    snapA     = sA;
    snapB     = sB;
    qv.push_back(v);
    qa.push_back(refCode(sA, r, PAT_A));
    qb.push_back(refCode(sB, r, PAT_B));
    qt.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    ev = qv.pop_front();
    ea = qa.pop_front();
    eb = qb.pop_front();
    et = qt.pop_front();
    if (ev) begin
      holdA = ea;
      holdB = eb;
    end
    chk(validA == ev, et, "codeValid SCSC", int'(validA), int'(ev));
    chk(validB == ev, et, "codeValid SNCC", int'(validB), int'(ev));
    chk(int'(codeA) == holdA, et, "fineCode SCSC", int'(codeA), holdA);
    chk(int'(codeB) == holdB, et, "fineCode SNCC", int'(codeB), holdB);
  endtask

  task automatic tick(bit v, int p, bit r, int glitch, logic [NTAP-1:0] noise, string tag);
    tickRaw(v, makeSnap(p, r, PAT_A, glitch, noise), makeSnap(p, r, PAT_B, glitch, noise), r, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(validA == 1'b0, "R8", "codeValid SCSC", int'(validA), 0);
    chk(validB == 1'b0, "R8", "codeValid SNCC", int'(validB), 0);
    chk(codeA == '0, "R8", "fineCode SCSC", int'(codeA), 0);
    chk(codeB == '0, "R8", "fineCode SNCC", int'(codeB), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      qv.push_back(1'b0); qa.push_back(0); qb.push_back(0); qt.push_back("R8");
    end

    // R5: empty and fully flipped lines, both edge directions
    tick(1, 0, 1, -1, '0, "R5");
    tick(1, 0, 0, -1, '0, "R5");
    tick(1, NTAP, 1, -1, '0, "R5");
    tick(1, NTAP, 0, -1, '0, "R5");

    // R3: every edge position, back to back, both directions (also R6 throughput)
    for (int p = 0; p <= NTAP; p++) tick(1, p, 1, -1, '0, "R3");
    for (int p = NTAP; p >= 0; p--) tick(1, p, 0, -1, '0, "R3");

    // R1: same edge, different wiring patterns give different counts
    tick(1, 2, 1, -1, '0, "R1");
    tick(1, 6, 1, -1, '0, "R1");
    tick(1, 13, 0, -1, '0, "R1");

    // R2: raw levels expose the carry inversion
    tickRaw(1, '0, '0, 1, "R2");
    tickRaw(1, '1, '1, 1, "R2");
    tickRaw(1, 32'h0000_FFFF, 32'h0000_FFFF, 0, "R2");

    // R4: isolated flipped tap above the edge
    tick(1, 4, 1, 10, '0, "R4");
    tick(1, 8, 0, 14, '0, "R4");
    tick(1, 0, 1, 6, '0, "R4");

    // R9: noise on unused taps
    tick(1, 9, 1, -1, 32'hA5A5_F00F, "R9");
    tick(1, 9, 1, -1, 32'h5A5A_0FF0, "R9");
    tick(1, 21, 0, -1, 32'hFFFF_FFFF, "R9");

    // R7: idle cycles with changing snapshots leave the result unchanged
    tick(1, 17, 1, -1, '0, "R7");
    for (int k = 0; k < 5; k++) tick(0, 3 + 5*k, k[0], -1, 32'h1234_5678, "R7");

    // R6: isolated and gapped valid strobes
    tick(1, 11, 1, -1, '0, "R6");
    tick(0, 0, 1, -1, '0, "R6");
    tick(1, 25, 0, -1, '0, "R6");
    tick(0, 0, 1, -1, '0, "R6");
    tick(0, 0, 1, -1, '0, "R6");
    tick(1, 30, 1, -1, '0, "R6");
    for (int k = 0; k < 4; k++) tick(0, 1, 1, -1, '0, "R6");

    report();
    $finish;
  end

endmodule